// File: doc/BRIEF.md
# Length-Checked XOR Frame Parser

This block sits behind a line receiver that has already recovered bytes and frame delimiters. It takes a byte stream together with start, end and frame-error strobes. Each accepted byte comes back out one clock later with a 3-bit field tag, so later logic can route header fields, payload and checksum without counting bytes itself.

The first byte of a frame gives the payload size in 4-byte words, less one. The three bytes after it are the source address, the destination address and the command. The data words follow, and then one checksum byte. The checksum byte must equal the XOR of every byte before it in the frame. At the end strobe the parser checks that the frame held exactly the expected number of bytes. Mismatches are reported as single-cycle error pulses.

Top module: `hdr_frame_parser`

## Requirements
- R1: While `rst_ni` is low, and on the first cycle after it is released, `byte_vld_o`, `cksum_err_o`, `size_err_o`, `tag_o` and `byte_o` are all zero.
- R2: Within a frame, byte positions 0, 1, 2 and 3 are tagged 0 (size), 1 (source), 2 (destination) and 3 (command).
- R3: Byte 0 sets the expected length L = 4 × (value + 1). The byte at position L is tagged 5 (checksum). A start strobe presets L to 4.
- R4: Every other accepted byte is tagged 4 (data). This includes bytes after the checksum position.
- R5: `cksum_err_o` pulses together with the checksum-tagged output byte exactly when that byte differs from the XOR of all earlier bytes of the frame. It never pulses with any other byte.
- R6: An end strobe inside a frame closes the frame. One cycle later it gives a `size_err_o` pulse unless the frame received exactly L + 1 bytes.
- R7: An accepted byte appears on `byte_o` with `byte_vld_o` high one clock after its `byte_vld_i` cycle.
- R8: A start strobe during a frame restarts it. The position counter and the XOR accumulator clear, and the next byte is tagged size again.
- R9: Before any start, after an end strobe, and after a `frame_err_i` pulse, the parser ignores bytes and end strobes until the next start. Ignored inputs give no output pulse.
- R10: The position counter (CNT_W bits, default 11) saturates at its maximum. Bytes past 2^CNT_W − 1 in an overlong frame keep the data tag and never alias back to a header or checksum position.
- R11: When strobes coincide, only the highest-priority one acts: start first, then frame error, then end, then byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame start strobe |
| end_i | input | 1 | Frame end strobe |
| frame_err_i | input | 1 | Line-level framing error strobe, aborts the frame |
| byte_vld_i | input | 1 | Input byte valid |
| byte_i | input | 8 | Input byte |
| byte_o | output | 8 | Tagged output byte |
| tag_o | output | 3 | Field tag: 0 size, 1 source, 2 destination, 3 command, 4 data, 5 checksum |
| byte_vld_o | output | 1 | Output byte valid |
| cksum_err_o | output | 1 | Checksum mismatch pulse |
| size_err_o | output | 1 | Frame length mismatch pulse |

## Verification
Every result is registered once. The tagged byte and its checksum flag are due at the first rising edge after the input byte is presented, and the size-error pulse at the first rising edge after the end strobe. The bench drives each stimulus on a falling edge and checks all outputs on the next falling edge, half a cycle after the result is due. Each frame is compared against a position/length/XOR model kept in the bench. Frames cover sizes 0 to 3 and 255, with good checksums, corrupted checksums, short and long frames, one overlong frame past counter saturation, and coinciding strobes.

// File: rtl/hdr_frame_pkg.sv
package hdr_frame_pkg;
  typedef enum logic [2:0] {
    TAG_SIZE  = 3'd0,
    TAG_SRC   = 3'd1,
    TAG_DST   = 3'd2,
    TAG_CMD   = 3'd3,
    TAG_DATA  = 3'd4,
    TAG_CKSUM = 3'd5
  } fld_tag_e;
endpackage

// File: rtl/hdr_len_ctr.sv
module hdr_len_ctr
  import hdr_frame_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [DW-1:0] byte_i,
  output fld_tag_e      tag_o,
  output logic          len_ok_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LEN_RST = CNT_W'(4);

  logic [CNT_W-1:0] cnt_q, exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      exp_q <= LEN_RST;
    end else if (clr_i) begin
      cnt_q <= '0;
      exp_q <= LEN_RST;
    end else if (adv_i) begin
      if (cnt_q == '0) exp_q <= CNT_W'({byte_i, 2'b00}) + LEN_RST;
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end
  end

  // header positions win over the checksum position (L is never below 4)
  always_comb begin
    if (cnt_q < CNT_W'(4))  tag_o = fld_tag_e'(cnt_q[2:0]);
    else if (cnt_q == exp_q) tag_o = TAG_CKSUM;
    else                     tag_o = TAG_DATA;
  end

  assign len_ok_o = (cnt_q == exp_q + CNT_W'(1));

  // R10
  cnt_no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_q >= $past(cnt_q));
  // R3
  exp_len_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exp_q[1:0] == 2'b00 && exp_q != '0);
endmodule

// File: rtl/hdr_xor_acc.sv
module hdr_xor_acc #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic [DW-1:0] byte_i,
  output logic          mismatch_o
);
  logic [DW-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (adv_i)  acc_q <= acc_q ^ byte_i;
  end

  // compare against earlier bytes only; current byte folds in afterwards
  assign mismatch_o = (byte_i != acc_q);
endmodule

// File: rtl/hdr_frame_parser.sv
module hdr_frame_parser
  import hdr_frame_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CNT_W = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          end_i,
  input  logic          frame_err_i,
  input  logic          byte_vld_i,
  input  logic [DW-1:0] byte_i,
  output logic [DW-1:0] byte_o,
  output logic [2:0]    tag_o,
  output logic          byte_vld_o,
  output logic          cksum_err_o,
  output logic          size_err_o
);
  logic     act_q;
  logic     do_abort, do_end, do_byte;
  fld_tag_e cur_tag;
  logic     len_ok, mismatch;

  // priority: start > frame error > end > byte
  assign do_abort = !start_i && frame_err_i;
  assign do_end   = !start_i && !frame_err_i && end_i && act_q;
  assign do_byte  = !start_i && !frame_err_i && !end_i && byte_vld_i && act_q;

  hdr_len_ctr #(.DW(DW), .CNT_W(CNT_W)) u_len_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start_i),
    .adv_i    (do_byte),
    .byte_i   (byte_i),
    .tag_o    (cur_tag),
    .len_ok_o (len_ok)
  );

  hdr_xor_acc #(.DW(DW)) u_xor_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (start_i),
    .adv_i      (do_byte),
    .byte_i     (byte_i),
    .mismatch_o (mismatch)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  act_q <= 1'b0;
    else if (start_i)             act_q <= 1'b1;
    else if (do_abort || do_end)  act_q <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_o      <= '0;
      tag_o       <= '0;
      byte_vld_o  <= 1'b0;
      cksum_err_o <= 1'b0;
      size_err_o  <= 1'b0;
    end else begin
      byte_vld_o  <= do_byte;
      cksum_err_o <= do_byte && (cur_tag == TAG_CKSUM) && mismatch;
      size_err_o  <= do_end && !len_ok;
      if (do_byte) begin
        byte_o <= byte_i;
        tag_o  <= cur_tag;
      end
    end
  end

  // R5
  cksum_on_tag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cksum_err_o |-> byte_vld_o && tag_o == TAG_CKSUM);
  // R7
  byte_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> byte_o == $past(byte_i));
  // R9
  vld_in_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> $past(act_q) && $past(byte_vld_i));
  // R6
  size_on_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    size_err_o |-> $past(end_i) && $past(act_q));
  // R11
  one_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_vld_o && size_err_o));
endmodule

// File: tb/hdr_frame_parser_bench.sv
module hdr_frame_parser_bench;
  localparam int CMAX = 2047;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 0, end_i = 0, frame_err_i = 0, byte_vld_i = 0;
  logic [7:0] byte_i = '0;
  logic [7:0] byte_o;
  logic [2:0] tag_o;
  logic       byte_vld_o, cksum_err_o, size_err_o;

  int n_run = 0, n_fail = 0;
  bit m_act = 0;
  int m_idx = 0, m_len = 4;
  logic [7:0] m_acc = '0;

  always #2 clk = ~clk;

  hdr_frame_parser u_hdr_frame_parser (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .end_i(end_i),
    .frame_err_i(frame_err_i), .byte_vld_i(byte_vld_i), .byte_i(byte_i),
    .byte_o(byte_o), .tag_o(tag_o), .byte_vld_o(byte_vld_o),
    .cksum_err_o(cksum_err_o), .size_err_o(size_err_o)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  // one stimulus: drive at falling edge, check at the next falling edge
  task automatic step(input bit s, input bit f, input bit e, input bit v,
                      input logic [7:0] b);
    bit e_vld, e_ck, e_se;
    int e_tag;
    string rq;
    start_i = s; frame_err_i = f; end_i = e; byte_vld_i = v; byte_i = b;
    e_vld = !s && !f && !e && v && m_act;
    e_se  = !s && !f && e && m_act && (m_idx != m_len + 1);
    if (m_idx < 4)            begin e_tag = m_idx; rq = "R2"; end
    else if (m_idx == m_len)  begin e_tag = 5;     rq = "R3"; end
    else                      begin e_tag = 4;     rq = (m_idx == CMAX) ? "R10" : "R4"; end
    e_ck = e_vld && (m_idx == m_len) && (b != m_acc);
    @(negedge clk);
    chk(byte_vld_o == e_vld, (s || !m_act) ? "R9" : "R7", byte_vld_o, e_vld);
    if (e_vld) begin
      chk(tag_o == 3'(e_tag), rq, tag_o, e_tag);
      chk(byte_o == b, "R7", byte_o, b);
    end
    chk(cksum_err_o == e_ck, "R5", cksum_err_o, e_ck);
    chk(size_err_o == e_se, "R6", size_err_o, e_se);
    if (s) begin m_act = 1; m_idx = 0; m_len = 4; m_acc = '0; end
    else if (f || (e && m_act)) m_act = 0;
    else if (v && m_act) begin
      if (m_idx == 0) m_len = 4 * (int'(b) + 1);
      m_acc ^= b;
      if (m_idx != CMAX) m_idx++;
    end
    start_i = 0; frame_err_i = 0; end_i = 0; byte_vld_i = 0;
  endtask

  // variant: 0 good, 1 bad checksum, 2 short by one, 3 long by one
  task automatic frame(input logic [7:0] sz, input int variant);
    int len;
    logic [7:0] acc;
    len = 4 * (int'(sz) + 1);
    acc = '0;
    step(1, 0, 0, 0, 8'h00);
    for (int i = 0; i < len + ((variant == 2) ? 0 : 1) + ((variant == 3) ? 1 : 0); i++) begin
      logic [7:0] b;
      if (i == 0) b = sz;
      else if (i == len) b = (variant == 1) ? (acc ^ 8'h5A) : acc;
      else b = 8'((i * 37 + int'(sz) * 11) & 8'hFF);
      acc ^= b;
      step(0, 0, 0, 1, b);
    end
    step(0, 0, 1, 0, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 outputs held low in reset
    chk({byte_vld_o, cksum_err_o, size_err_o, tag_o, byte_o} == '0, "R1",
        {byte_vld_o, cksum_err_o, size_err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk({byte_vld_o, cksum_err_o, size_err_o, tag_o, byte_o} == '0, "R1",
        {byte_vld_o, cksum_err_o, size_err_o}, 0);
    // R9 nothing acts before a start
    step(0, 0, 0, 1, 8'h12);
    step(0, 0, 1, 0, 8'h00);
    step(0, 1, 0, 0, 8'h00);
    // R2 R3 R4 R5 R6 sweep of sizes and frame variants
    for (int sz = 0; sz < 4; sz++)
      for (int vr = 0; vr < 4; vr++) frame(8'(sz), vr);
    frame(8'd255, 0);
    frame(8'd255, 1);
    // R9 after end, bytes ignored
    step(0, 0, 0, 1, 8'h44);
    // R9 frame error aborts, later byte and end ignored
    step(1, 0, 0, 0, 8'h00);
    step(0, 0, 0, 1, 8'h01);
    step(0, 0, 0, 1, 8'h02);
    step(0, 1, 0, 1, 8'h03);
    step(0, 0, 0, 1, 8'h04);
    step(0, 0, 1, 0, 8'h00);
    // R8 restart mid-frame
    step(1, 0, 0, 0, 8'h00);
    step(0, 0, 0, 1, 8'h02);
    step(0, 0, 0, 1, 8'h77);
    step(1, 0, 0, 0, 8'h00);
    step(0, 0, 0, 1, 8'h00);
    for (int i = 1; i < 4; i++) step(0, 0, 0, 1, 8'(i));
    step(0, 0, 0, 1, 8'h00 ^ 8'h01 ^ 8'h02 ^ 8'h03);
    step(0, 0, 1, 0, 8'h00);
    // R11 coinciding strobes
    step(1, 0, 1, 1, 8'h09);
    step(0, 1, 1, 1, 8'h09);
    step(1, 0, 0, 0, 8'h00);
    step(0, 0, 1, 1, 8'h09);
    // R10 overlong frame past saturation
    step(1, 0, 0, 0, 8'h00);
    for (int i = 0; i < 2100; i++) step(0, 0, 0, 1, 8'(i));
    step(0, 0, 1, 0, 8'h00);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule